// File: doc/BRIEF.md
# Two-Entry Non-Blocking Miss Tracker

This block follows data-cache line misses that are still in flight, so the pipeline can keep issuing after a load misses. Each tracked miss keeps the line address it waits on and the set of destination registers that will receive its data. A later miss to a line that is already tracked joins the existing entry and does not take a new one.

Every cycle the block compares the two source register tags of the issuing instruction against the pending destinations. It raises a stall when the instruction needs data that has not arrived yet. It also raises a stall when the instruction is a load or store and every entry is busy. Refill beats come in on one or more return channels, each tagged with its line address. A line is `LINE_BYTES*8/BEAT_W` beats long, four by default. The entry for a line is freed when its final beat is accepted. The stall it caused drops in that same cycle, and the slot can be reused in that same cycle.

The fill datapath, the cache arrays and the register file are outside this block. The memory system decides when beats arrive (at the earliest three cycles after the request). The tracker only counts the beats.

Top module: `nbmiss_tracker`

## Requirements
- R1: After a synchronous active-high reset, `pend_count` is 0 and `stall` is 0 for any issuing instruction, memory or not.
- R2: A miss on `miss_valid` is recorded at the clock edge and raises `pend_count` by one from the next cycle. The miss does not stall anything by itself, and an independent load or store proceeds while fewer than `ENTRIES` misses are pending.
- R3: An issuing instruction stalls when either `issue_src_a` or `issue_src_b` equals a destination register of a pending, not-retiring entry.
- R4: When `ENTRIES` (2) misses are pending and none of them retires this cycle, an issuing instruction with `issue_is_mem`=1 stalls even if it depends on nothing.
- R5: An instruction with `issue_is_mem`=0 and no dependency proceeds while all entries are busy.
- R6: A miss whose line address equals that of a pending, not-retiring entry joins that entry. `pend_count` is unchanged and the new destination register becomes pending too.
- R7: An entry retires when the `BEATS`-th (4th by default) refill beat for its line is accepted. A beat counts only on a channel whose `refill_valid` bit is 1 and whose line field (channel p at bits `p*LINE_AW +: LINE_AW` of `refill_line`) equals the entry's line. `pend_count` drops on the next cycle.
- R8: In the cycle an entry's final beat is accepted, that entry causes no stall, whether through a dependency or through fullness.
- R9: Two entries whose final beats arrive in the same cycle on different channels both retire in that cycle.
- R10: A new miss may take a slot that retires in the same cycle. A miss to the line being retired opens a fresh entry that needs a full set of beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | An instruction is trying to issue this cycle |
| issue_is_mem | input | 1 | The issuing instruction is a load or store |
| issue_src_a | input | REG_W | First source register tag |
| issue_src_b | input | REG_W | Second source register tag |
| miss_valid | input | 1 | A data-cache miss is reported this cycle |
| miss_line | input | LINE_AW | Line address of the miss |
| miss_dst | input | REG_W | Destination register waiting on the miss |
| refill_valid | input | RF_PORTS | One bit per return channel: a beat is present |
| refill_line | input | RF_PORTS*LINE_AW | Line address of each channel's beat, channel p at p*LINE_AW |
| stall | output | 1 | Hold the issuing instruction this cycle |
| pend_count | output | CNT_OUT_W | Number of occupied entries (registered) |

## Verification
If the tracker loses an entry, the next dependent instruction issues without a stall in its very first issue cycle, and `pend_count` is one low at the following edge. A wrong beat counter moves the cycle in which the stall drops and `pend_count` falls, and the move is exactly one cycle per miscounted beat. A failed merge shows up as `pend_count` reading 2 one cycle after a repeated line, which then makes independent loads and stores stall. The bench mirrors the requirements in its own model and compares `stall` in every driven cycle and `pend_count` after every edge, so each of these faults is reported in the cycle where it first appears.

// File: rtl/nbmt_pkg.sv
package nbmt_pkg;
  localparam int DEF_ADDR_W     = 32;
  localparam int DEF_LINE_BYTES = 32;
  localparam int DEF_BEAT_W     = 64;
  localparam int DEF_REG_W      = 5;
  localparam int DEF_ENTRIES    = 2;
  localparam int DEF_RF_PORTS   = 2;

  function automatic int cnt_width(input int beats);
    return (beats > 1) ? $clog2(beats) : 1;
  endfunction
endpackage

// File: rtl/nbmt_pick.sv
module nbmt_pick #(
  parameter int N = 2
) (
  input  logic [N-1:0] free_i,
  output logic [N-1:0] grant_o
);
  always_comb begin
    logic found;
    found   = 1'b0;
    grant_o = '0;
    for (int i = 0; i < N; i++) begin
      if (free_i[i] && !found) begin
        grant_o[i] = 1'b1;
        found      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/nbmt_entry.sv
module nbmt_entry #(
  parameter int LINE_AW = 27,
  parameter int NREGS   = 32,
  parameter int REG_W   = 5,
  parameter int BEATS   = 4,
  parameter int CNT_W   = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               alloc_en,
  input  logic               merge_en,
  input  logic [LINE_AW-1:0] new_line,
  input  logic [REG_W-1:0]   new_dst,
  input  logic               beat_en,
  output logic               valid_o,
  output logic [LINE_AW-1:0] line_o,
  output logic [NREGS-1:0]   dstmask_o,
  output logic               retire_o
);
  logic               valid_q;
  logic [LINE_AW-1:0] line_q;
  logic [NREGS-1:0]   mask_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [NREGS-1:0]   dst_bit;

  assign dst_bit  = NREGS'(1) << new_dst;
  assign retire_o = valid_q && beat_en && (cnt_q == CNT_W'(BEATS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      line_q  <= '0;
      mask_q  <= '0;
      cnt_q   <= '0;
    end else if (alloc_en) begin
      valid_q <= 1'b1;
      line_q  <= new_line;
      mask_q  <= dst_bit;
      cnt_q   <= '0;
    end else if (retire_o) begin
      valid_q <= 1'b0;
      mask_q  <= '0;
      cnt_q   <= '0;
    end else if (valid_q) begin
      if (beat_en)  cnt_q  <= cnt_q + CNT_W'(1);
      if (merge_en) mask_q <= mask_q | dst_bit;
    end
  end

  assign valid_o   = valid_q;
  assign line_o    = line_q;
  assign dstmask_o = mask_q;

  // R7
  idle_cnt_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_q |-> (cnt_q == '0));
  // R2
  mask_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    valid_q |-> (mask_q != '0));
  // R7
  retire_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (retire_o && !alloc_en) |=> !valid_q);
endmodule

// File: rtl/nbmiss_tracker.sv
module nbmiss_tracker
  import nbmt_pkg::*;
#(
  parameter int ADDR_W     = DEF_ADDR_W,
  parameter int LINE_BYTES = DEF_LINE_BYTES,
  parameter int BEAT_W     = DEF_BEAT_W,
  parameter int REG_W      = DEF_REG_W,
  parameter int ENTRIES    = DEF_ENTRIES,
  parameter int RF_PORTS   = DEF_RF_PORTS,
  localparam int LINE_AW   = ADDR_W - $clog2(LINE_BYTES),
  localparam int CNT_OUT_W = $clog2(ENTRIES + 1)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        issue_valid,
  input  logic                        issue_is_mem,
  input  logic [REG_W-1:0]            issue_src_a,
  input  logic [REG_W-1:0]            issue_src_b,
  input  logic                        miss_valid,
  input  logic [LINE_AW-1:0]          miss_line,
  input  logic [REG_W-1:0]            miss_dst,
  input  logic [RF_PORTS-1:0]         refill_valid,
  input  logic [RF_PORTS*LINE_AW-1:0] refill_line,
  output logic                        stall,
  output logic [CNT_OUT_W-1:0]        pend_count
);
  localparam int BEATS = (LINE_BYTES * 8) / BEAT_W;
  localparam int CNT_W = cnt_width(BEATS);
  localparam int NREGS = 1 << REG_W;

  logic [ENTRIES-1:0] ent_valid, ent_retire, ent_beat, live;
  logic [ENTRIES-1:0] miss_hit, merge_en, alloc_en, grant;
  logic [LINE_AW-1:0] ent_line [ENTRIES];
  logic [NREGS-1:0]   ent_mask [ENTRIES];
  logic [NREGS-1:0]   src_bits;
  logic               dep_hit, all_busy;
  logic [CNT_OUT_W-1:0] live_cnt;

  assign live     = ent_valid & ~ent_retire;
  assign src_bits = (NREGS'(1) << issue_src_a) | (NREGS'(1) << issue_src_b);

  genvar gi;
  generate
    for (gi = 0; gi < ENTRIES; gi++) begin : g_ent
      always_comb begin
        ent_beat[gi] = 1'b0;
        for (int p = 0; p < RF_PORTS; p++) begin
          if (refill_valid[p] && refill_line[p*LINE_AW +: LINE_AW] == ent_line[gi])
            ent_beat[gi] = 1'b1;
        end
      end

      assign miss_hit[gi] = live[gi] && (ent_line[gi] == miss_line);
      assign merge_en[gi] = miss_valid && miss_hit[gi];
      assign alloc_en[gi] = miss_valid && !(|miss_hit) && grant[gi];

      nbmt_entry #(
        .LINE_AW(LINE_AW), .NREGS(NREGS), .REG_W(REG_W),
        .BEATS(BEATS), .CNT_W(CNT_W)
      ) entry_i (
        .clk      (clk),
        .rst      (rst),
        .alloc_en (alloc_en[gi]),
        .merge_en (merge_en[gi]),
        .new_line (miss_line),
        .new_dst  (miss_dst),
        .beat_en  (ent_beat[gi]),
        .valid_o  (ent_valid[gi]),
        .line_o   (ent_line[gi]),
        .dstmask_o(ent_mask[gi]),
        .retire_o (ent_retire[gi])
      );
    end
  endgenerate

  nbmt_pick #(.N(ENTRIES)) pick_i (
    .free_i (~live),
    .grant_o(grant)
  );

  always_comb begin
    dep_hit = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (live[i] && |(ent_mask[i] & src_bits)) dep_hit = 1'b1;
    end
  end

  assign live_cnt = CNT_OUT_W'($countones(live));
  assign all_busy = (live_cnt == CNT_OUT_W'(ENTRIES));
  assign stall    = issue_valid && (dep_hit || (issue_is_mem && all_busy));

  always_ff @(posedge clk) begin
    if (rst) pend_count <= '0;
    else     pend_count <= CNT_OUT_W'($countones(live | alloc_en));
  end

  function automatic logic has_line(input logic [LINE_AW-1:0] a);
    logic r;
    r = 1'b0;
    for (int i = 0; i < ENTRIES; i++)
      if (ent_valid[i] && ent_line[i] == a) r = 1'b1;
    return r;
  endfunction

  // R2
  pend_count_match_chk: assert property (@(posedge clk) disable iff (rst)
    pend_count == CNT_OUT_W'($countones(ent_valid)));
  // R2
  miss_recorded_chk: assert property (@(posedge clk) disable iff (rst)
    (miss_valid && ((|miss_hit) || (|(~live)))) |=> has_line($past(miss_line)));
  // R4
  full_mem_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && issue_is_mem && pend_count == CNT_OUT_W'(ENTRIES) && !(|ent_retire))
      |-> stall);

  generate
    for (gi = 0; gi < ENTRIES; gi++) begin : g_uniq
      for (genvar gj = gi + 1; gj < ENTRIES; gj++) begin : g_pair
        // R6
        unique_line_chk: assert property (@(posedge clk) disable iff (rst)
          !(ent_valid[gi] && ent_valid[gj] && ent_line[gi] == ent_line[gj]));
      end
    end
  endgenerate
endmodule

// File: tb/nbmiss_tracker_tb_top.sv
`timescale 1ns/1ps
module nbmiss_tracker_tb_top;
  localparam int LAW = 27;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic           iv_s = 0, im_s = 0, mv_s = 0;
  logic [4:0]     sa_s = 0, sb_s = 0, md_s = 0;
  logic [LAW-1:0] ml_s = 0;
  logic [1:0]     rv_s = 0;
  logic [2*LAW-1:0] rl_s = 0;
  logic           stall;
  logic [1:0]     pend_count;

  int checks = 0, fails = 0;

  nbmiss_tracker dut_i (
    .clk(clk), .rst(rst),
    .issue_valid(iv_s), .issue_is_mem(im_s),
    .issue_src_a(sa_s), .issue_src_b(sb_s),
    .miss_valid(mv_s), .miss_line(ml_s), .miss_dst(md_s),
    .refill_valid(rv_s), .refill_line(rl_s),
    .stall(stall), .pend_count(pend_count)
  );

  logic           m_v [2];
  logic [LAW-1:0] m_l [2];
  logic [31:0]    m_m [2];
  int             m_c [2];

  function automatic logic m_beat(int i);
    return m_v[i] && ((rv_s[0] && rl_s[LAW-1:0] == m_l[i]) ||
                      (rv_s[1] && rl_s[2*LAW-1:LAW] == m_l[i]));
  endfunction
  function automatic logic m_ret(int i);
    return m_beat(i) && m_c[i] == 3;
  endfunction
  function automatic int m_live_cnt();
    int n = 0;
    for (int i = 0; i < 2; i++) if (m_v[i] && !m_ret(i)) n++;
    return n;
  endfunction
  function automatic logic m_dep();
    logic d = 0;
    for (int i = 0; i < 2; i++)
      if (m_v[i] && !m_ret(i) && (m_m[i][sa_s] || m_m[i][sb_s])) d = 1;
    return d;
  endfunction
  function automatic logic m_stall();
    return iv_s && (m_dep() || (im_s && m_live_cnt() == 2));
  endfunction
  function automatic string stall_tag();
    if (m_dep()) return "R3";
    if (m_live_cnt() == 2) return im_s ? "R4" : "R5";
    return "R2";
  endfunction
  function automatic int m_count();
    int n = 0;
    for (int i = 0; i < 2; i++) if (m_v[i]) n++;
    return n;
  endfunction

  task automatic m_update();
    logic ret [2];
    logic bt  [2];
    int h;
    for (int i = 0; i < 2; i++) begin ret[i] = m_ret(i); bt[i] = m_beat(i); end
    for (int i = 0; i < 2; i++) begin
      if (ret[i]) begin m_v[i] = 0; m_m[i] = 0; m_c[i] = 0; end
      else if (bt[i]) m_c[i]++;
    end
    if (mv_s) begin
      h = -1;
      for (int i = 0; i < 2; i++) if (m_v[i] && m_l[i] == ml_s) h = i;
      if (h >= 0) m_m[h][md_s] = 1'b1;
      else begin
        for (int i = 0; i < 2; i++) begin
          if (!m_v[i] && h < 0) begin
            m_v[i] = 1; m_l[i] = ml_s; m_m[i] = 32'd1 << md_s; m_c[i] = 0; h = i;
          end
        end
      end
    end
  endtask

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic iv, input logic im, input logic [4:0] sa, input logic [4:0] sb,
                      input logic mv, input logic [LAW-1:0] ml, input logic [4:0] md,
                      input logic [1:0] rv, input logic [LAW-1:0] r0, input logic [LAW-1:0] r1,
                      input string tag);
    logic e;
    string t;
    @(negedge clk);
    iv_s = iv; im_s = im; sa_s = sa; sb_s = sb;
    mv_s = mv; ml_s = ml; md_s = md; rv_s = rv; rl_s = {r1, r0};
    #1;
    e = m_stall();
    t = (tag == "") ? stall_tag() : tag;
    check(stall == e, t, stall, e);
    @(posedge clk);
    m_update();
    #1;
    check(pend_count == 2'(m_count()), (tag == "") ? "R7" : tag, pend_count, m_count());
  endtask

  task automatic idle_issue(input logic im, input logic [4:0] sa, input logic [4:0] sb, input string tag);
    step(1, im, sa, sb, 0, 0, 0, 2'b00, 0, 0, tag);
  endtask

  task automatic beats(input logic [1:0] rv, input logic [LAW-1:0] r0, input logic [LAW-1:0] r1,
                       input int n, input string tag);
    for (int k = 0; k < n; k++) step(1, 1, 30, 31, 0, 0, 0, rv, r0, r1, tag);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int pick0, pick1;
    logic [1:0] rv;
    logic [LAW-1:0] r0, r1;
    logic mv;
    for (int i = 0; i < 2; i++) begin m_v[i] = 0; m_l[i] = 0; m_m[i] = 0; m_c[i] = 0; end
    void'($urandom(32'h5eed_7001));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    iv_s = 1; im_s = 1; sa_s = 0; sb_s = 0; #1;
    check(stall == 0, "R1", stall, 0);
    check(pend_count == 0, "R1", pend_count, 0);

    // R2: miss does not stall, independent load proceeds
    step(1, 1, 1, 2, 1, 27'd1, 5, 2'b00, 0, 0, "R2");
    idle_issue(1, 1, 2, "R2");
    // R3: dependency on either source port
    idle_issue(1, 5, 2, "R3");
    idle_issue(0, 3, 5, "R3");
    // R6: merge into the same line
    step(1, 1, 1, 2, 1, 27'd1, 9, 2'b00, 0, 0, "R6");
    idle_issue(1, 9, 0, "R6");
    // R4 / R5: two outstanding
    step(1, 0, 1, 2, 1, 27'd2, 11, 2'b00, 0, 0, "R2");
    idle_issue(1, 1, 2, "R4");
    idle_issue(0, 1, 2, "R5");
    // R7: beats for line 1; line 3 (no entry) ignored
    beats(2'b01, 27'd3, 0, 2, "R7");
    beats(2'b01, 27'd1, 0, 3, "R7");
    // R8: final beat lifts dependent stall in the same cycle
    step(1, 1, 5, 0, 0, 0, 0, 2'b01, 27'd1, 0, "R8");
    idle_issue(1, 5, 9, "R7");
    // R9: two final beats in one cycle
    step(1, 0, 1, 2, 1, 27'd3, 12, 2'b00, 0, 0, "R2");
    beats(2'b11, 27'd2, 27'd3, 3, "R4");
    step(1, 1, 11, 12, 0, 0, 0, 2'b11, 27'd2, 27'd3, "R9");
    idle_issue(1, 11, 12, "R9");
    // R10: slot reuse and re-miss on retiring line
    step(0, 0, 0, 0, 1, 27'd1, 1, 2'b00, 0, 0, "R2");
    step(0, 0, 0, 0, 1, 27'd2, 2, 2'b00, 0, 0, "R2");
    beats(2'b01, 27'd1, 0, 3, "R4");
    step(1, 1, 7, 7, 1, 27'd4, 3, 2'b01, 27'd1, 0, "R10");
    idle_issue(1, 3, 0, "R10");
    beats(2'b01, 27'd2, 0, 3, "R4");
    step(1, 0, 6, 6, 1, 27'd2, 4, 2'b01, 27'd2, 0, "R10");
    idle_issue(0, 4, 0, "R10");
    idle_issue(0, 2, 0, "R10");
    beats(2'b01, 27'd2, 0, 3, "R10");
    idle_issue(1, 4, 0, "R10");
    step(1, 0, 4, 4, 0, 0, 0, 2'b01, 27'd2, 0, "R8");

    // constrained random
    for (int c = 0; c < 3000; c++) begin
      rv = 0; r0 = 0; r1 = 0;
      pick0 = $urandom_range(0, 1);
      if (m_v[pick0] && $urandom_range(0, 1)) begin rv[0] = 1; r0 = m_l[pick0]; end
      pick1 = 1 - pick0;
      if (m_v[pick1] && $urandom_range(0, 1)) begin rv[1] = 1; r1 = m_l[pick1]; end
      rv_s = rv; rl_s = {r1, r0};
      ml_s = 27'($urandom_range(1, 4));
      mv = ($urandom_range(0, 9) < 3);
      if (mv) begin
        logic ok = (m_live_cnt() < 2);
        for (int i = 0; i < 2; i++) if (m_v[i] && !m_ret(i) && m_l[i] == ml_s) ok = 1;
        mv = ok;
      end
      step($urandom_range(0, 3) != 0, $urandom_range(0, 1), 5'($urandom_range(0, 7)),
           5'($urandom_range(0, 7)), mv, ml_s, 5'($urandom_range(0, 7)), rv, r0, r1, "");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule